// File: doc/BRIEF.md
# Timer Compare/Capture Channel

One general-purpose register channel that works beside a free-running up-counter. A 4-bit mode code, written by software, gives the channel one of three roles. As a compare channel it drives an output pin: writing the mode sets the pin to a chosen starting level, and each later counter match sets the pin low, sets it high or inverts it. As a pin capture channel it copies the counter value into its register on a chosen edge of the input pin. As a cross-channel capture channel it copies the counter value whenever a neighbouring counter counts.

Two conditions suppress the channel's events. The neighbour-driven capture is void while the neighbour runs from the undivided system clock. Buffer operation blocks every capture and every compare event, whatever the mode. A sticky event flag records each match or capture until software clears it. The counter and the prescaler lie outside the block.

Top module: `tcc_channel`

## Requirements
- R1: After reset pin_out is 0, pin_oe is 0, evt_flag is 0, gr_q is 0 and the mode code is 0000.
- R2: Mode codes 0000 and 0100 keep pin_oe at 0 and leave pin_out unchanged. A compare match still sets evt_flag.
- R3: Writing mode 0001, 0010 or 0011 sets pin_out to 0 and pin_oe to 1 at the write edge. On a later match the pin goes to 0 (0001), goes to 1 (0010) or inverts (0011).
- R4: Writing mode 0101, 0110 or 0111 sets pin_out to 1 and pin_oe to 1 at the write edge. On a later match the pin goes to 0 (0101), goes to 1 (0110) or inverts (0111).
- R5: A match is a cycle with cnt_en high, cnt_val equal to gr_q and mode bit 3 at 0. At the next edge the match is registered. pin_out and evt_flag change at the edge after that.
- R6: pin_in passes through SYNC_STAGES flip-flops before edge detection. Mode 1000 captures on a rising edge, 1001 on a falling edge, and 1010 or 1011 on either edge. gr_q takes cnt_val at the (SYNC_STAGES+1)-th edge after pin_in changes. Every code with bit 3 set holds pin_oe at 0.
- R7: Modes 11xx load cnt_val into gr_q at the edge that samples nbr_cnt_pulse high. No capture occurs while nbr_psc is all zeros.
- R8: While buf_mode is 1, no capture loads gr_q, no match sets evt_flag, and no match moves pin_out.
- R9: evt_flag stays set until a cycle with flag_clr. If a new event and flag_clr land on the same edge, the flag stays set.
- R10: gr_wr loads gr_wdata into gr_q. A capture on the same edge takes priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter-enable cycle qualifier |
| cnt_val | input | CNT_W | Current counter value |
| nbr_cnt_pulse | input | 1 | Count event of the neighbouring counter |
| nbr_psc | input | PSC_W | Neighbour prescaler select (all zeros = undivided clock) |
| buf_mode | input | 1 | Register serves as a buffer; blocks all events |
| pin_in | input | 1 | Asynchronous capture pin |
| mode_wr | input | 1 | Mode code write strobe |
| mode_wdata | input | 4 | New mode code |
| gr_wr | input | 1 | General register write strobe |
| gr_wdata | input | CNT_W | General register write data |
| flag_clr | input | 1 | Write-one-to-clear strobe for evt_flag |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output pin enable |
| gr_q | output | CNT_W | General register contents |
| evt_flag | output | 1 | Sticky match/capture flag |

## Verification
The bench builds the channel with CNT_W=12 so that the all-ones counter value 12'hFFF can be matched and captured at the register's full width. It uses SYNC_STAGES=3, a non-default depth, so that the check of the capture latency depends on the parameter and not on a fixed two-stage delay. PSC_W stays at 3, which allows the all-zero prescaler code to be compared with a divided setting.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_INV  = 2'b11
  } pin_act_e;

  typedef enum logic [2:0] {
    SRC_OFF  = 3'd0,
    SRC_RISE = 3'd1,
    SRC_FALL = 3'd2,
    SRC_ANY  = 3'd3,
    SRC_NBR  = 3'd4
  } cap_src_e;

  typedef struct packed {
    logic     is_cmp;
    logic     oe;
    logic     init_vld;
    logic     init_lvl;
    pin_act_e act;
    cap_src_e src;
  } mode_dec_t;

  // Bit 3 splits compare from capture; in compare, bit 2 is the start level
  // and bits 1:0 the match action; in capture, bit 2 picks the neighbour.
  function automatic mode_dec_t mode_decode(input logic [3:0] code);
    mode_dec_t d;
    d.is_cmp   = ~code[3];
    d.oe       = 1'b0;
    d.init_vld = 1'b0;
    d.init_lvl = code[2];
    d.act      = ACT_NONE;
    d.src      = SRC_OFF;
    if (!code[3]) begin
      d.act      = pin_act_e'(code[1:0]);
      d.oe       = (code[1:0] != 2'b00);
      d.init_vld = (code[1:0] != 2'b00);
    end else if (code[2]) begin
      d.src = SRC_NBR;
    end else begin
      case (code[1:0])
        2'b00:   d.src = SRC_RISE;
        2'b01:   d.src = SRC_FALL;
        default: d.src = SRC_ANY;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/tcc_pin_sync.sv
module tcc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign rise =  chain_q[STAGES-1] & ~prev_q;
  assign fall = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/tcc_cap_sel.sv
module tcc_cap_sel
  import tcc_pkg::*;
#(
  parameter int PSC_W = 3
) (
  input  cap_src_e         src,
  input  logic             rise,
  input  logic             fall,
  input  logic             nbr_pulse,
  input  logic [PSC_W-1:0] nbr_psc,
  input  logic             blocked,
  output logic             cap_evt
);
  logic raw;

  always_comb begin
    case (src)
      SRC_RISE: raw = rise;
      SRC_FALL: raw = fall;
      SRC_ANY:  raw = rise | fall;
      SRC_NBR:  raw = nbr_pulse & (nbr_psc != '0);
      default:  raw = 1'b0;
    endcase
  end

  assign cap_evt = raw & ~blocked;
endmodule

// File: rtl/tcc_cmp_out.sv
module tcc_cmp_out
  import tcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] ref_val,
  input  logic             is_cmp,
  input  logic             blocked,
  input  pin_act_e         act,
  input  logic             load_init,
  input  logic             init_lvl,
  output logic             pin,
  output logic             match_evt
);
  logic match_d, match_q;
  logic pin_d, pin_q, pin_en;

  assign match_d = is_cmp & ~blocked & cnt_en & (cnt_val == ref_val);

  always_comb begin
    pin_d = pin_q;
    if (load_init) begin
      pin_d = init_lvl;
    end else if (match_q) begin
      case (act)
        ACT_LOW:  pin_d = 1'b0;
        ACT_HIGH: pin_d = 1'b1;
        ACT_INV:  pin_d = ~pin_q;
        default:  pin_d = pin_q;
      endcase
    end
  end

  assign pin_en = load_init | match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= match_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin       = pin_q;
  assign match_evt = match_q;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PSC_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             nbr_cnt_pulse,
  input  logic [PSC_W-1:0] nbr_psc,
  input  logic             buf_mode,
  input  logic             pin_in,
  input  logic             mode_wr,
  input  logic [3:0]       mode_wdata,
  input  logic             gr_wr,
  input  logic [CNT_W-1:0] gr_wdata,
  input  logic             flag_clr,
  output logic             pin_out,
  output logic             pin_oe,
  output logic [CNT_W-1:0] gr_q,
  output logic             evt_flag
);
  logic [3:0]       mode_q, mode_d;
  logic [CNT_W-1:0] reg_q, reg_d;
  logic             flag_q, flag_d;
  logic             reg_en, flag_en;
  mode_dec_t        cur_dec, new_dec;
  logic             rise, fall, cap_evt, match_evt, evt_set;

  assign cur_dec = mode_decode(mode_q);
  assign new_dec = mode_decode(mode_wdata);

  tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .din (pin_in), .rise (rise), .fall (fall)
  );

  tcc_cap_sel #(.PSC_W(PSC_W)) u_cap (
    .src (cur_dec.src), .rise (rise), .fall (fall), .nbr_pulse (nbr_cnt_pulse),
    .nbr_psc (nbr_psc), .blocked (buf_mode), .cap_evt (cap_evt)
  );

  tcc_cmp_out #(.CNT_W(CNT_W)) u_cmp (
    .clk (clk), .rst_n (rst_n), .cnt_en (cnt_en), .cnt_val (cnt_val),
    .ref_val (reg_q), .is_cmp (cur_dec.is_cmp), .blocked (buf_mode),
    .act (cur_dec.act), .load_init (mode_wr & new_dec.init_vld),
    .init_lvl (new_dec.init_lvl), .pin (pin_out), .match_evt (match_evt)
  );

  assign evt_set = cap_evt | match_evt;

  always_comb begin
    mode_d = mode_wr ? mode_wdata : mode_q;
    reg_d  = reg_q;
    if (cap_evt)    reg_d = cnt_val;
    else if (gr_wr) reg_d = gr_wdata;
    flag_d = flag_q;
    if (evt_set)       flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  assign reg_en  = cap_evt | gr_wr;
  assign flag_en = evt_set | flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 4'b0000;
      reg_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= mode_d;
      if (reg_en)  reg_q  <= reg_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign pin_oe   = cur_dec.oe;
  assign gr_q     = reg_q;
  assign evt_flag = flag_q;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [3:0]       mode_wdata,
  input logic             buf_mode,
  input logic             gr_wr,
  input logic             flag_clr,
  input logic [PSC_W-1:0] nbr_psc,
  input logic [3:0]       mode,
  input logic             pin_out,
  input logic             pin_oe,
  input logic [CNT_W-1:0] gr_q,
  input logic             evt_flag
);
  a_r2_quiet_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[3] && mode[1:0] == 2'b00) |-> !pin_oe);

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata[3:2] == 2'b00 && mode_wdata[1:0] != 2'b00) |=> (!pin_out && pin_oe));

  a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_wdata[3:2] == 2'b01 && mode_wdata[1:0] != 2'b00) |=> (pin_out && pin_oe));

  a_r6_capture_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mode[3] |-> !pin_oe);

  a_r7_fast_nbr_void: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] == 2'b11 && nbr_psc == '0 && !gr_wr) |=> $stable(gr_q));

  a_r8_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_mode && !gr_wr) |=> $stable(gr_q));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_clr) |=> evt_flag);
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .mode_wr (mode_wr), .mode_wdata (mode_wdata),
  .buf_mode (buf_mode), .gr_wr (gr_wr), .flag_clr (flag_clr), .nbr_psc (nbr_psc),
  .mode (mode_q), .pin_out (pin_out), .pin_oe (pin_oe), .gr_q (gr_q),
  .evt_flag (evt_flag)
);

// File: tb/sim_tcc_channel.sv
module sim_tcc_channel;
  localparam int CW   = 12;
  localparam int PW   = 3;
  localparam int SYNC = 3;

  logic          clk, rst_n;
  logic          cnt_en, nbr_cnt_pulse, buf_mode, pin_in, mode_wr, gr_wr, flag_clr;
  logic [CW-1:0] cnt_val, gr_wdata, gr_q;
  logic [PW-1:0] nbr_psc;
  logic [3:0]    mode_wdata;
  logic          pin_out, pin_oe, evt_flag;
  int            checks = 0, errs = 0;
  bit            done = 0;

  tcc_channel #(.CNT_W(CW), .PSC_W(PW), .SYNC_STAGES(SYNC)) u0 (
    .clk (clk), .rst_n (rst_n), .cnt_en (cnt_en), .cnt_val (cnt_val),
    .nbr_cnt_pulse (nbr_cnt_pulse), .nbr_psc (nbr_psc), .buf_mode (buf_mode),
    .pin_in (pin_in), .mode_wr (mode_wr), .mode_wdata (mode_wdata), .gr_wr (gr_wr),
    .gr_wdata (gr_wdata), .flag_clr (flag_clr), .pin_out (pin_out), .pin_oe (pin_oe),
    .gr_q (gr_q), .evt_flag (evt_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_wr = 1'b1; mode_wdata = m; tick(); mode_wr = 1'b0;
  endtask

  task automatic set_gr(input logic [CW-1:0] v);
    gr_wr = 1'b1; gr_wdata = v; tick(); gr_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  // one matching cycle, then wait for the registered pin update
  task automatic hit(input logic [CW-1:0] v);
    cnt_val = v; cnt_en = 1'b1; tick(); cnt_en = 1'b0; tick();
  endtask

  task automatic t_reset();
    chk("R1 pin_out", 32'(pin_out), 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 evt_flag", 32'(evt_flag), 0);
    chk("R1 gr_q", 32'(gr_q), 0);
  endtask

  task automatic t_compare_low_start();
    set_gr(12'h064);
    set_mode(4'b0011);
    chk("R3 start level 0", 32'(pin_out), 0);
    chk("R3 oe on", 32'(pin_oe), 1);
    cnt_val = 12'h064; cnt_en = 1'b1; tick(); cnt_en = 1'b0;
    chk("R5 pin waits one more edge", 32'(pin_out), 0);
    chk("R5 flag waits one more edge", 32'(evt_flag), 0);
    tick();
    chk("R3 toggle to 1", 32'(pin_out), 1);
    chk("R5 flag on match", 32'(evt_flag), 1);
    hit(12'h064);
    chk("R3 toggle back to 0", 32'(pin_out), 0);
    set_mode(4'b0010);
    hit(12'h064);
    chk("R3 code 0010 sets 1", 32'(pin_out), 1);
    set_mode(4'b0001);
    chk("R3 code 0001 restarts at 0", 32'(pin_out), 0);
    hit(12'h064);
    chk("R3 code 0001 match gives 0", 32'(pin_out), 0);
  endtask

  task automatic t_compare_high_start();
    set_gr(12'hFFF);
    set_mode(4'b0101);
    chk("R4 start level 1", 32'(pin_out), 1);
    hit(12'hFFF);
    chk("R4 code 0101 match gives 0", 32'(pin_out), 0);
    set_mode(4'b0110);
    chk("R4 code 0110 start 1", 32'(pin_out), 1);
    hit(12'hFFF);
    chk("R4 code 0110 match keeps 1", 32'(pin_out), 1);
    set_mode(4'b0111);
    hit(12'hFFF);
    chk("R4 code 0111 toggles to 0", 32'(pin_out), 0);
  endtask

  task automatic t_no_match();
    clear_flag();
    set_mode(4'b0111);
    hit(12'hFFE);
    chk("R5 unequal value no change", 32'(pin_out), 1);
    cnt_val = 12'hFFF; cnt_en = 1'b0; tick(); tick();
    chk("R5 no enable no change", 32'(pin_out), 1);
    chk("R5 no enable no flag", 32'(evt_flag), 0);
  endtask

  task automatic t_disabled_output();
    set_mode(4'b0100);
    chk("R2 code 0100 oe off", 32'(pin_oe), 0);
    chk("R2 code 0100 pin held", 32'(pin_out), 1);
    set_mode(4'b0000);
    hit(12'hFFF);
    chk("R2 oe off", 32'(pin_oe), 0);
    chk("R2 pin held on match", 32'(pin_out), 1);
    chk("R2 flag still set", 32'(evt_flag), 1);
    clear_flag();
    chk("R9 flag cleared", 32'(evt_flag), 0);
  endtask

  task automatic t_pin_capture();
    set_mode(4'b1000);
    chk("R6 capture oe off", 32'(pin_oe), 0);
    cnt_val = 12'h123; pin_in = 1'b1;
    repeat (SYNC) tick();
    chk("R6 not yet captured", 32'(gr_q), 32'h0FFF);
    tick();
    chk("R6 rising capture", 32'(gr_q), 32'h123);
    chk("R6 flag on capture", 32'(evt_flag), 1);
    clear_flag();
    cnt_val = 12'h222; pin_in = 1'b0;
    repeat (SYNC + 2) tick();
    chk("R6 falling ignored in 1000", 32'(gr_q), 32'h123);
    set_mode(4'b1001);
    pin_in = 1'b1; repeat (SYNC + 2) tick();
    chk("R6 rising ignored in 1001", 32'(gr_q), 32'h123);
    cnt_val = 12'h345; pin_in = 1'b0; repeat (SYNC + 1) tick();
    chk("R6 falling capture", 32'(gr_q), 32'h345);
    set_mode(4'b1011);
    cnt_val = 12'h456; pin_in = 1'b1; repeat (SYNC + 1) tick();
    chk("R6 both-edge rising", 32'(gr_q), 32'h456);
    cnt_val = 12'h567; pin_in = 1'b0; repeat (SYNC + 1) tick();
    chk("R6 both-edge falling", 32'(gr_q), 32'h567);
  endtask

  task automatic t_nbr_capture();
    clear_flag();
    set_mode(4'b1100);
    nbr_psc = 3'b001; cnt_val = 12'hABC;
    nbr_cnt_pulse = 1'b1; tick(); nbr_cnt_pulse = 1'b0;
    chk("R7 neighbour capture", 32'(gr_q), 32'hABC);
    chk("R7 flag", 32'(evt_flag), 1);
    clear_flag();
    nbr_psc = 3'b000; cnt_val = 12'h0DE;
    nbr_cnt_pulse = 1'b1; tick(); nbr_cnt_pulse = 1'b0; tick();
    chk("R7 undivided clock void", 32'(gr_q), 32'hABC);
    chk("R7 undivided no flag", 32'(evt_flag), 0);
    nbr_psc = 3'b010;
    nbr_cnt_pulse = 1'b1; flag_clr = 1'b1; tick(); nbr_cnt_pulse = 1'b0; flag_clr = 1'b0;
    chk("R9 set beats clear", 32'(evt_flag), 1);
    cnt_val = 12'h777;
    nbr_cnt_pulse = 1'b1; gr_wr = 1'b1; gr_wdata = 12'h111; tick();
    nbr_cnt_pulse = 1'b0; gr_wr = 1'b0;
    chk("R10 capture beats write", 32'(gr_q), 32'h777);
    set_gr(12'h0F0);
    chk("R10 software write", 32'(gr_q), 32'h0F0);
  endtask

  task automatic t_buffer();
    clear_flag();
    buf_mode = 1'b1;
    set_mode(4'b1010);
    cnt_val = 12'h999; pin_in = 1'b1; repeat (SYNC + 2) tick();
    chk("R8 no pin capture", 32'(gr_q), 32'h0F0);
    set_mode(4'b1100);
    nbr_psc = 3'b011; nbr_cnt_pulse = 1'b1; tick(); nbr_cnt_pulse = 1'b0;
    chk("R8 no neighbour capture", 32'(gr_q), 32'h0F0);
    set_mode(4'b0011);
    hit(12'h0F0);
    chk("R8 no compare pin change", 32'(pin_out), 0);
    chk("R8 no flag", 32'(evt_flag), 0);
    buf_mode = 1'b0;
    hit(12'h0F0);
    chk("R8 released compare works", 32'(pin_out), 1);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; cnt_val = '0; nbr_cnt_pulse = 1'b0; nbr_psc = '0;
    buf_mode = 1'b0; pin_in = 1'b0; mode_wr = 1'b0; mode_wdata = '0;
    gr_wr = 1'b0; gr_wdata = '0; flag_clr = 1'b0;
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_compare_low_start();
    t_compare_high_start();
    t_no_match();
    t_disabled_output();
    t_pin_capture();
    t_nbr_capture();
    t_buffer();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule